// File: doc/BRIEF.md
# Precision Time Counter with Trigger Capture

This block keeps the running time of a precision timing domain as a fixed-point count of nanoseconds. On every reference tick it adds a programmable step to a wide accumulator. The step is a 32.32 value: an integer count of nanoseconds with a binary fraction below it. Software sets the step to (10^9 · 2^32) / f_ref, where f_ref is the reference rate in Hz. The reference is either a one-cycle internal tick input or the rising edges of one of several external reference pins. A configuration field picks the source.

A second set of input pins carries external trigger events, for example a one-pulse-per-second signal. When capture is enabled, a transition of the selected polarity on the selected trigger pin freezes the current nanosecond count into a snapshot register. It also raises a sticky event flag. Reading the snapshot clears the flag. If a second event arrives before that read, an overrun flag is raised. Software reaches configuration, time, step and snapshot through a simple register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset, the time (nanoseconds and fraction), step, configuration and snapshot all read as zero, and both event flags are low.
- R2: While configuration bit 0 (run) is clear, the time does not change on any tick.
- R3: With run set, each reference tick adds the 64-bit step to the time. The step's upper 32 bits are whole nanoseconds and its lower 32 bits are the fraction. A carry out of the 32-bit fraction adds one nanosecond.
- R4: Configuration bit 1 clear uses the internal tick input, and the time updates at the edge where it is high. Bit 1 set uses the rising edges of the reference pin numbered by bits 7:2. Each such edge advances the time once, at the third clock edge after the pin rises. Pins that are not selected have no effect.
- R5: With configuration bit 8 set, a transition on the trigger pin numbered by bits 15:10 captures the nanosecond count. Bit 9 picks the polarity: 0 for rising, 1 for falling. The snapshot is written at the third clock edge after the transition and holds the count present just before that edge.
- R6: A trigger level held steady captures only once, and transitions of the other polarity capture nothing. With bit 8 clear, no capture occurs and the snapshot keeps its value.
- R7: A capture sets the event-valid flag. A read at offset 0xF20 returns the snapshot and clears the flag.
- R8: A capture while event-valid is already set overwrites the snapshot and sets the overrun flag.
- R9: A capture at the same edge as a snapshot read leaves event-valid set and overrun clear. The snapshot holds the new value.
- R10: Register offsets are 0xF00 configuration (16 bits), 0xF08 time fraction (32 bits), 0xF10 time nanoseconds (64 bits), 0xF18 step and 0xF20 snapshot. A write to 0xF08 or 0xF10 loads that part of the time and replaces any tick at that edge.
- R11: A step write takes effect from the following tick. A tick at the same edge as the write still uses the old step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_tick | input | 1 | Internal reference tick, one cycle per period |
| ext_ref | input | NUM_PINS | External reference pins (asynchronous) |
| trig_in | input | NUM_PINS | External trigger pins (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| evt_valid | output | 1 | Sticky capture-pending flag |
| evt_ovf | output | 1 | Capture overrun flag |

## Verification
A trigger capture and a software read of the snapshot can land on the same clock edge. The bench makes this happen by counting the synchronizer delay from the trigger transition and holding the read strobe exactly on the capture edge. It starts with both flags already set. It then checks that event-valid stays set, overrun clears, and the next read returns the newly captured count. A second collision, a step write on the same edge as a tick, is judged from the time read back over two successive ticks.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] OFS_CFG  = 12'hF00;
   localparam logic [ADDR_W-1:0] OFS_FRAC = 12'hF08;
   localparam logic [ADDR_W-1:0] OFS_NS   = 12'hF10;
   localparam logic [ADDR_W-1:0] OFS_STEP = 12'hF18;
   localparam logic [ADDR_W-1:0] OFS_SNAP = 12'hF20;

   localparam int CFG_W      = 16;
   localparam int SEL_W      = 6;
   localparam int B_RUN      = 0;
   localparam int B_EXTREF   = 1;
   localparam int B_REFSEL   = 2;
   localparam int B_CAPEN    = 8;
   localparam int B_CAPFALL  = 9;
   localparam int B_TRIGSEL  = 10;
endpackage

// File: rtl/ptp_tc_pin_edge.sv
module ptp_tc_pin_edge #(
   parameter int NUM_PINS    = 4,
   parameter int SEL_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins,
   input  logic [SEL_W-1:0]    sel,
   input  logic                falling,
   output logic                pulse
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ptp_tc_pin_edge: SYNC_STAGES must be at least 2");
      end
      if (NUM_PINS > (1 << SEL_W)) begin : g_bad_pins
         $error("ptp_tc_pin_edge: NUM_PINS exceeds select range");
      end
   endgenerate

   logic                   picked;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   // Out-of-range selects read as a quiet low pin.
   always_comb begin
      picked = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (sel == SEL_W'(i)) picked = pins[i];
      end
   end

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= picked;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[SYNC_STAGES-1];
   end

   assign pulse = falling ? (~sync_q[SYNC_STAGES-1] &  last_q)
                          : ( sync_q[SYNC_STAGES-1] & ~last_q);
endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
   parameter int NS_W     = 64,
   parameter int FRAC_W   = 32,
   parameter int STEP_W   = 64,
   parameter int DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic [STEP_W-1:0] step,
   input  logic              ld_ns,
   input  logic              ld_frac,
   input  logic [DATA_W-1:0] ld_data,
   output logic [NS_W-1:0]   ns_q,
   output logic [FRAC_W-1:0] frac_q
);
   localparam int ACC_W = NS_W + FRAC_W;

   generate
      if (NS_W > DATA_W || FRAC_W > DATA_W || STEP_W > ACC_W) begin : g_bad_w
         $error("ptp_tc_accum: width parameters inconsistent");
      end
   endgenerate

   logic [ACC_W-1:0] sum;
   assign sum = {ns_q, frac_q} + ACC_W'(step);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q   <= '0;
         frac_q <= '0;
      end else if (ld_ns) begin
         ns_q   <= ld_data[NS_W-1:0];
      end else if (ld_frac) begin
         frac_q <= ld_data[FRAC_W-1:0];
      end else if (advance) begin
         {ns_q, frac_q} <= sum;
      end
   end
endmodule

// File: rtl/ptp_tc_capture.sv
module ptp_tc_capture #(
   parameter int NS_W = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic            snap_rd,
   input  logic [NS_W-1:0] ns_now,
   output logic [NS_W-1:0] snap_q,
   output logic            valid_q,
   output logic            ovf_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q  <= '0;
         valid_q <= 1'b0;
         ovf_q   <= 1'b0;
      end else begin
         if (cap) snap_q <= ns_now;

         if (cap)          valid_q <= 1'b1;
         else if (snap_rd) valid_q <= 1'b0;

         if (snap_rd)               ovf_q <= 1'b0;
         else if (cap && valid_q)   ovf_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
   import ptp_tc_pkg::*;
#(
   parameter int NUM_PINS    = 4,
   parameter int NS_W        = 64,
   parameter int FRAC_W      = 32,
   parameter int STEP_INT_W  = 32,
   parameter int DATA_W      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                int_tick,
   input  logic [NUM_PINS-1:0] ext_ref,
   input  logic [NUM_PINS-1:0] trig_in,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                evt_valid,
   output logic                evt_ovf
);
   localparam int STEP_W = STEP_INT_W + FRAC_W;

   generate
      if (STEP_W > DATA_W || CFG_W > DATA_W) begin : g_bad_step
         $error("ptp_time_counter: step or config wider than data bus");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_q;
   logic [STEP_W-1:0] step_q;
   logic [NS_W-1:0]   ns_q;
   logic [FRAC_W-1:0] frac_q;
   logic [NS_W-1:0]   snap_q;
   logic              wr_cfg, wr_frac, wr_ns, wr_step, snap_rd;
   logic              ref_pulse, trig_pulse, tick, advance, cap_pulse;

   assign wr_cfg  = bus_wr && (bus_addr == OFS_CFG);
   assign wr_frac = bus_wr && (bus_addr == OFS_FRAC);
   assign wr_ns   = bus_wr && (bus_addr == OFS_NS);
   assign wr_step = bus_wr && (bus_addr == OFS_STEP);
   assign snap_rd = bus_rd && (bus_addr == OFS_SNAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         step_q <= '0;
      end else begin
         if (wr_cfg)  cfg_q  <= bus_wdata[CFG_W-1:0];
         if (wr_step) step_q <= bus_wdata[STEP_W-1:0];
      end
   end

   ptp_tc_pin_edge #(
      .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .pins(ext_ref),
      .sel(cfg_q[B_REFSEL +: SEL_W]), .falling(1'b0), .pulse(ref_pulse)
   );

   ptp_tc_pin_edge #(
      .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_trig_edge (
      .clk(clk), .rst_n(rst_n), .pins(trig_in),
      .sel(cfg_q[B_TRIGSEL +: SEL_W]), .falling(cfg_q[B_CAPFALL]),
      .pulse(trig_pulse)
   );

   assign tick      = cfg_q[B_EXTREF] ? ref_pulse : int_tick;
   assign advance   = tick && cfg_q[B_RUN];
   assign cap_pulse = trig_pulse && cfg_q[B_CAPEN];

   ptp_tc_accum #(
      .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .DATA_W(DATA_W)
   ) u_accum (
      .clk(clk), .rst_n(rst_n), .advance(advance), .step(step_q),
      .ld_ns(wr_ns), .ld_frac(wr_frac), .ld_data(bus_wdata),
      .ns_q(ns_q), .frac_q(frac_q)
   );

   ptp_tc_capture #(.NS_W(NS_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .cap(cap_pulse), .snap_rd(snap_rd),
      .ns_now(ns_q), .snap_q(snap_q), .valid_q(evt_valid), .ovf_q(evt_ovf)
   );

   always_comb begin
      case (bus_addr)
         OFS_CFG:  bus_rdata = DATA_W'(cfg_q);
         OFS_FRAC: bus_rdata = DATA_W'(frac_q);
         OFS_NS:   bus_rdata = DATA_W'(ns_q);
         OFS_STEP: bus_rdata = DATA_W'(step_q);
         OFS_SNAP: bus_rdata = DATA_W'(snap_q);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ptp_tc_checker.sv
module ptp_tc_checker #(
   parameter int NS_W = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            cap_en,
   input logic            wr_ns,
   input logic            wr_frac,
   input logic            cap_pulse,
   input logic            snap_rd,
   input logic [NS_W-1:0] ns_q,
   input logic [NS_W-1:0] snap_q,
   input logic            evt_valid,
   input logic            evt_ovf
);
   assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_ns && !wr_frac) |=> $stable(ns_q));

   assert_one_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> !cap_pulse);

   assert_no_cap_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(snap_q));

   assert_valid_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> evt_valid);

   assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_rd && !cap_pulse) |=> (!evt_valid && !evt_ovf));

   assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_pulse && evt_valid && !snap_rd) |=> evt_ovf);

   assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_pulse && snap_rd) |=> (evt_valid && !evt_ovf));

   assert_snap_takes_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pulse |=> (snap_q == $past(ns_q)));
endmodule

bind ptp_time_counter ptp_tc_checker #(.NS_W(NS_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .run(cfg_q[0]), .cap_en(cfg_q[8]),
   .wr_ns(wr_ns), .wr_frac(wr_frac), .cap_pulse(cap_pulse),
   .snap_rd(snap_rd), .ns_q(ns_q), .snap_q(snap_q),
   .evt_valid(evt_valid), .evt_ovf(evt_ovf)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb_top;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          int_tick = 1'b0;
   logic [NP-1:0] ext_ref = '0;
   logic [NP-1:0] trig_in = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [63:0]   bus_wdata = '0;
   logic [63:0]   bus_rdata;
   logic          evt_valid, evt_ovf;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   ptp_time_counter dut_i (
      .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_ref(ext_ref),
      .trig_in(trig_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_valid(evt_valid), .evt_ovf(evt_ovf)
   );

   // Reference model of the time, from the requirements (internal ticks only).
   logic [63:0] m_ns, m_step;
   logic [31:0] m_fr;
   logic        m_run, m_ext;

   function automatic logic [95:0] add_step(logic [63:0] ns, logic [31:0] fr,
                                           logic [63:0] st);
      return {ns, fr} + {32'b0, st};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ns <= '0; m_fr <= '0; m_step <= '0; m_run <= 1'b0; m_ext <= 1'b0;
      end else begin
         if (bus_wr && bus_addr == 12'hF00) begin
            m_run <= bus_wdata[0];
            m_ext <= bus_wdata[1];
         end
         if (bus_wr && bus_addr == 12'hF18) m_step <= bus_wdata;
         if (bus_wr && bus_addr == 12'hF10) m_ns <= bus_wdata;
         else if (bus_wr && bus_addr == 12'hF08) m_fr <= bus_wdata[31:0];
         else if (m_run && !m_ext && int_tick) {m_ns, m_fr} <= add_step(m_ns, m_fr, m_step);
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [11:0] a, output logic [63:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #400000;
      n_err++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] d, exp;
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(12'hF00, d); check("R1 cfg", d, 0);
      rd(12'hF10, d); check("R1 ns", d, 0);
      rd(12'hF08, d); check("R1 frac", d, 0);
      rd(12'hF18, d); check("R1 step", d, 0);
      rd(12'hF20, d); check("R1 snap", d, 0);
      check("R1 flags", {62'b0, evt_valid, evt_ovf}, 0);

      // R3 fractional carry: 1.5 ns per tick, three ticks
      wr(12'hF00, 64'h1);
      wr(12'hF18, 64'h0000_0001_8000_0000);
      @(negedge clk); int_tick = 1'b1;
      idle(3); int_tick = 1'b0;
      peek(12'hF10, d); check("R3 ns after 3x1.5", d, 4);
      peek(12'hF08, d); check("R3 frac after 3x1.5", d, 64'h8000_0000);

      // R2 run clear: ticks ignored
      wr(12'hF00, 64'h0);
      @(negedge clk); int_tick = 1'b1;
      idle(5); int_tick = 1'b0;
      peek(12'hF10, d); check("R2 ns frozen", d, 4);
      peek(12'hF08, d); check("R2 frac frozen", d, 64'h8000_0000);

      // R11 step write on same edge as a tick
      wr(12'hF00, 64'h1);
      wr(12'hF10, 64'd0);
      wr(12'hF08, 64'd0);
      wr(12'hF18, 64'd5 << 32);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 12'hF18; bus_wdata = 64'd7 << 32; int_tick = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      peek(12'hF10, d); check("R11 old step on write edge", d, 5);
      @(negedge clk); int_tick = 1'b0;
      peek(12'hF10, d); check("R11 new step next tick", d, 12);

      // Random internal ticks and step changes against the model (R3, R10)
      for (int it = 0; it < 600; it++) begin
         @(negedge clk);
         int_tick = ($urandom % 3) != 0;
         if (($urandom % 50) == 0) begin
            bus_wr = 1'b1; bus_addr = 12'hF18;
            bus_wdata = {32'($urandom % 1000), 32'($urandom)};
            @(negedge clk); bus_wr = 1'b0;
         end
         if ((it % 40) == 39) begin
            peek(12'hF10, d); check("R3 random ns", d, m_ns);
            peek(12'hF08, d); check("R3 random frac", d, {32'b0, m_fr});
         end
      end
      @(negedge clk); int_tick = 1'b0;

      // R4 external reference pin 2, step 10 ns
      wr(12'hF00, 64'h0B);
      wr(12'hF10, 64'd0);
      wr(12'hF18, 64'd10 << 32);
      ext_ref[2] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      peek(12'hF10, d); check("R4 not before third edge", d, 0);
      @(negedge clk);
      peek(12'hF10, d); check("R4 advance at third edge", d, 10);
      idle(4); ext_ref[2] = 1'b0; idle(4);
      for (int k = 0; k < 2; k++) begin
         ext_ref[2] = 1'b1; idle(4); ext_ref[2] = 1'b0; idle(4);
      end
      peek(12'hF10, d); check("R4 three edges", d, 30);
      for (int k = 0; k < 3; k++) begin
         ext_ref[1] = 1'b1; idle(4); ext_ref[1] = 1'b0; idle(4);
      end
      peek(12'hF10, d); check("R4 unselected pin ignored", d, 30);
      int_tick = 1'b1; idle(3); int_tick = 1'b0;
      peek(12'hF10, d); check("R4 int tick ignored in ext mode", d, 30);

      // Capture: rising edge on trig pin 1, time frozen (R5, R6, R7)
      wr(12'hF00, 64'h0501);
      wr(12'hF10, 64'd1000);
      trig_in[1] = 1'b1;
      idle(6);
      check("R7 valid after capture", {63'b0, evt_valid}, 1);
      check("R6 held level single capture", {63'b0, evt_ovf}, 0);
      rd(12'hF20, d); check("R5 rising snapshot", d, 1000);
      check("R7 read clears valid", {63'b0, evt_valid}, 0);

      // Falling polarity (R5, R6)
      wr(12'hF00, 64'h0701);
      wr(12'hF10, 64'd2000);
      trig_in[1] = 1'b0;
      idle(6);
      check("R5 falling captured", {63'b0, evt_valid}, 1);
      wr(12'hF10, 64'd2500);
      trig_in[1] = 1'b1;
      idle(6);
      check("R6 rising ignored in falling mode", {63'b0, evt_ovf}, 0);
      rd(12'hF20, d); check("R5 falling snapshot", d, 2000);

      // Capture disabled (R6)
      wr(12'hF00, 64'h0401);
      trig_in[1] = 1'b0; idle(5); trig_in[1] = 1'b1; idle(5); trig_in[1] = 1'b0; idle(5);
      check("R6 disabled no valid", {63'b0, evt_valid}, 0);
      peek(12'hF20, d); check("R6 disabled snapshot kept", d, 2000);

      // Overrun (R8)
      wr(12'hF00, 64'h0501);
      wr(12'hF10, 64'd3000);
      trig_in[1] = 1'b1; idle(5); trig_in[1] = 1'b0; idle(3);
      wr(12'hF10, 64'd3100);
      trig_in[1] = 1'b1; idle(5);
      check("R8 overrun flag", {63'b0, evt_ovf}, 1);
      peek(12'hF20, d); check("R8 snapshot overwritten", d, 3100);

      // Read and capture on the same edge (R9)
      trig_in[1] = 1'b0; idle(4);
      wr(12'hF10, 64'd3200);
      trig_in[1] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      bus_rd = 1'b1; bus_addr = 12'hF20;
      #1 d = bus_rdata;
      check("R9 read returns prior snapshot", d, 3100);
      @(negedge clk); bus_rd = 1'b0;
      #1;
      check("R9 valid kept", {63'b0, evt_valid}, 1);
      check("R9 overrun cleared", {63'b0, evt_ovf}, 0);
      rd(12'hF20, d); check("R9 new snapshot", d, 3200);

      // Capture of running time (R5)
      wr(12'hF18, 64'd3 << 32);
      trig_in[1] = 1'b0; idle(4);
      @(negedge clk); int_tick = 1'b1; idle(3);
      trig_in[1] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      exp = m_ns;
      idle(3); int_tick = 1'b0;
      rd(12'hF20, d); check("R5 running snapshot", d, exp);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule